// File: doc/BRIEF.md
# Cascaded Byte ALU Sequencer

This block performs 8-bit or 16-bit arithmetic, logic, load/store and shift operations using one 8-bit ALU. A start pulse captures an operation code, a width flag and a carry input. For a narrow operation the block makes one pass over the low operand bytes. For a wide operation it makes two passes in sequence. Between the passes it carries the arithmetic carry or the shifted-out bit from the first byte into the second. Only one byte of each operand comes in per pass, matching an 8-bit data bus. The block tells the surrounding fetch logic which half it needs in each pass.

Each operation takes a register-side operand A and a memory-side operand B. When the last pass finishes, the block raises a one-cycle completion pulse. At the same time it updates a registered 16-bit result and the negative, zero, carry and overflow flags. These outputs then hold steady until the next completion.

Top module: `wide_alu_seq`

## Requirements
- R1: After `start` is sampled high while idle, `busy` is high for one pass cycle (narrow) or two (wide). `done` then pulses high for exactly one cycle with `busy` low.
- R2: Operation codes are 0 OR, 1 AND, 2 XOR, 3 add with carry, 4 subtract with borrow (A + ~B + carry), 5 compare, 6 load (result B), 7 store (result A), 8 increment B, 9 decrement B, 10 shift left B, 11 rotate left B through carry, 12 shift right B, 13 rotate right B through carry. Codes 14 and 15 behave as load.
- R3: In a wide operation, every code except 12 and 13 requests the low byte first (`fetch_hi` = 0) and then the high byte. The low pass's carry or shifted-out bit feeds bit 0 / the carry of the high pass.
- R4: Wide codes 12 and 13 request the high byte first, then the low byte. The bit shifted out of the high byte becomes bit 7 of the low byte.
- R5: `flag_n` is bit 15 (wide) or bit 7 (narrow) of the flag value. `flag_z` is set only when every byte of the flag value is zero. The flag value is the difference for compare and the result otherwise.
- R6: `flag_v` is the signed overflow of the most significant byte for codes 3 and 4, and 0 for all other codes.
- R7: `flag_c` is the final carry-out for codes 3, 4 and 5, and the last shifted-out bit for codes 10–13. For all other codes it equals the captured carry input.
- R8: Increment and decrement propagate across the byte boundary: 0x00FF+1 = 0x0100, 0x0100−1 = 0x00FF, 0xFFFF+1 = 0x0000.
- R9: Compare leaves the result equal to A. Its flags come from A − B, and carry set means no borrow.
- R10: `start`, `op`, `wide` and `carry_in` are ignored while `busy` is high.
- R11: Reset clears `busy`, `done`, `result` and all flags. `result` and the flags change only in the cycle in which `done` rises.
- R12: A narrow operation uses only the low operand bytes and returns zero in `result[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| carry_in | input | 1 | Incoming carry |
| opa_byte | input | 8 | Requested byte of operand A |
| opb_byte | input | 8 | Requested byte of operand B |
| busy | output | 1 | A pass is in progress |
| fetch_hi | output | 1 | Byte half wanted in this pass (1 = high) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bound checker watches several properties on every cycle. It checks the pass count and the position of the completion pulse for each width. It checks the order of byte requests for right shifts against all other codes. It also checks that the result holds between completions, that zero agrees with the result for every code except compare, and that overflow stays clear outside add and subtract. The values themselves can be shown only by the bench scenarios: carry and shift-bit chaining across the byte boundary, borrow and overflow at the sign edge, compare flags, and that inputs poked during a busy operation are ignored. A behavioural reference model computes each expected word and flag set directly at full width.

// File: rtl/wseq_pkg.sv
// Shared definitions for the cascaded byte ALU sequencer.
// Assumes a 4-bit operation code; codes 14 and 15 alias the load operation.
package wseq_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_OR  = 4'd0,  OP_AND = 4'd1,  OP_XOR = 4'd2,  OP_ADC = 4'd3,
        OP_SBC = 4'd4,  OP_CMP = 4'd5,  OP_LDA = 4'd6,  OP_STA = 4'd7,
        OP_INC = 4'd8,  OP_DEC = 4'd9,  OP_ASL = 4'd10, OP_ROL = 4'd11,
        OP_LSR = 4'd12, OP_ROR = 4'd13, OP_RS0 = 4'd14, OP_RS1 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} seq_state_e;

    // Right shifts walk the word from the top byte down.
    function automatic logic high_first(alu_op_e op);
        return (op == OP_LSR) || (op == OP_ROR);
    endfunction

    // Chain bit fed into the first pass.
    function automatic logic seed_chain(alu_op_e op, logic cin);
        case (op)
            OP_ADC, OP_SBC, OP_ROL, OP_ROR: return cin;
            OP_CMP, OP_INC:                 return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    // Operations whose final chain bit becomes the carry flag.
    function automatic logic writes_carry(alu_op_e op);
        case (op)
            OP_ADC, OP_SBC, OP_CMP,
            OP_ASL, OP_ROL, OP_LSR, OP_ROR: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/wseq_byte_alu.sv
// Combinational single-byte ALU.
// Takes one byte of each operand and a chain bit (carry or shift-in).
// Returns the written byte, the byte that feeds N/Z, the chain bit out and
// the signed overflow of this byte. Assumes the caller sequences the passes.
module wseq_byte_alu
    import wseq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  alu_op_e           op,
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic              chain_in,
    output logic [BYTE_W-1:0] res,
    output logic [BYTE_W-1:0] flag_val,
    output logic              chain_out,
    output logic              ovf
);
    localparam int MSB = BYTE_W - 1;

    logic [BYTE_W-1:0] lhs, rhs;
    logic [BYTE_W:0]   sum;

    // Select adder operands for each arithmetic flavour.
    always_comb begin
        lhs = a;
        rhs = b;
        case (op)
            OP_SBC, OP_CMP: rhs = ~b;
            OP_INC: begin lhs = b; rhs = '0; end
            OP_DEC: begin lhs = b; rhs = '1; end
            default: ;
        endcase
    end

    assign sum = {1'b0, lhs} + {1'b0, rhs} + {{BYTE_W{1'b0}}, chain_in};

    // Form the output byte, the chain bit and overflow.
    always_comb begin
        res       = b;
        flag_val  = '0;
        chain_out = 1'b0;
        ovf       = 1'b0;
        case (op)
            OP_OR:  res = a | b;
            OP_AND: res = a & b;
            OP_XOR: res = a ^ b;
            OP_ADC, OP_SBC: begin
                res       = sum[MSB:0];
                chain_out = sum[BYTE_W];
                ovf       = (lhs[MSB] == rhs[MSB]) && (sum[MSB] != lhs[MSB]);
            end
            OP_CMP: begin
                res       = a;
                chain_out = sum[BYTE_W];
            end
            OP_STA: res = a;
            OP_INC, OP_DEC: begin
                res       = sum[MSB:0];
                chain_out = sum[BYTE_W];
            end
            OP_ASL, OP_ROL: begin
                res       = {b[MSB-1:0], chain_in};
                chain_out = b[MSB];
            end
            OP_LSR, OP_ROR: begin
                res       = {chain_in, b[MSB:1]};
                chain_out = b[0];
            end
            default: res = b;
        endcase
        flag_val = (op == OP_CMP) ? sum[MSB:0] : res;
    end
endmodule

// File: rtl/wseq_ctrl.sv
// Pass sequencer: captures the command while idle, runs one or two passes,
// and tells the fetch side which byte half each pass uses.
// Assumes start is a level sampled only in the idle state.
module wseq_ctrl
    import wseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OP_W-1:0]  op_in,
    input  logic             wide_in,
    input  logic             cin_in,
    output alu_op_e          op_q,
    output logic             wide_q,
    output logic             cin_q,
    output logic             pass_en,
    output logic             second,
    output logic             fetch_hi,
    output logic             last_pass
);
    seq_state_e state;

    // Advance the pass state and latch the command on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_OR;
            wide_q <= 1'b0;
            cin_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    op_q   <= alu_op_e'(op_in);
                    wide_q <= wide_in;
                    cin_q  <= cin_in;
                    state  <= ST_FIRST;
                end
                ST_FIRST:  state <= wide_q ? ST_SECOND : ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Decode pass position and byte half.
    always_comb begin
        pass_en   = (state != ST_IDLE);
        second    = (state == ST_SECOND);
        fetch_hi  = wide_q & (second ^ high_first(op_q));
        last_pass = pass_en & (~wide_q | second);
    end
endmodule

// File: rtl/wseq_join.sv
// Chains the two passes and composes the registered word and flags.
// Holds the first pass byte, flag byte and chain bit; updates outputs only
// on the final pass. Assumes the ALU reports overflow per byte.
module wseq_join
    import wseq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  alu_op_e             op_q,
    input  logic                wide_q,
    input  logic                cin_q,
    input  logic                pass_en,
    input  logic                second,
    input  logic                fetch_hi,
    input  logic                last_pass,
    input  logic [BYTE_W-1:0]   res,
    input  logic [BYTE_W-1:0]   flag_val,
    input  logic                chain_out,
    input  logic                ovf,
    output logic                chain_to_alu,
    output logic                done,
    output logic [2*BYTE_W-1:0] result,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_c,
    output logic                flag_v
);
    localparam int MSB    = BYTE_W - 1;
    localparam int WORD_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] first_res_q, first_flag_q;
    logic              chain_q;
    logic [WORD_W-1:0] word_nx;
    logic              n_nx, z_nx;

    assign chain_to_alu = second ? chain_q : seed_chain(op_q, cin_q);

    // Compose the final word and N/Z from the current and held bytes.
    always_comb begin
        z_nx = (flag_val == '0);
        n_nx = flag_val[MSB];
        if (!wide_q) begin
            word_nx = {{BYTE_W{1'b0}}, res};
        end else if (fetch_hi) begin
            word_nx = {res, first_res_q};
            z_nx    = z_nx && (first_flag_q == '0);
        end else begin
            word_nx = {first_res_q, res};
            z_nx    = z_nx && (first_flag_q == '0);
            n_nx    = first_flag_q[MSB];
        end
    end

    // Hold the first pass outputs for the second pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_res_q  <= '0;
            first_flag_q <= '0;
            chain_q      <= 1'b0;
        end else if (pass_en && !second) begin
            first_res_q  <= res;
            first_flag_q <= flag_val;
            chain_q      <= chain_out;
        end
    end

    // Register the completed word and flags with the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_c <= 1'b0;
            flag_v <= 1'b0;
        end else begin
            done <= last_pass;
            if (last_pass) begin
                result <= word_nx;
                flag_n <= n_nx;
                flag_z <= z_nx;
                flag_c <= writes_carry(op_q) ? chain_out : cin_q;
                flag_v <= ovf;
            end
        end
    end
endmodule

// File: rtl/wide_alu_seq.sv
// Top of the cascaded byte ALU sequencer: one 8-bit ALU, a pass sequencer
// and a result joiner. Assumes the fetch side presents the byte half named
// by fetch_hi during each busy cycle.
module wide_alu_seq
    import wseq_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic              wide,
    input  logic              carry_in,
    input  logic [BYTE_W-1:0] opa_byte,
    input  logic [BYTE_W-1:0] opb_byte,
    output logic              busy,
    output logic              fetch_hi,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);
    alu_op_e           op_q;
    logic              wide_q, cin_q, pass_en, second, last_pass;
    logic              chain_in, chain_out, ovf;
    logic [BYTE_W-1:0] res, flag_val;

    assign busy = pass_en;

    wseq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op),
        .wide_in(wide), .cin_in(carry_in), .op_q(op_q), .wide_q(wide_q),
        .cin_q(cin_q), .pass_en(pass_en), .second(second),
        .fetch_hi(fetch_hi), .last_pass(last_pass)
    );

    wseq_byte_alu #(.BYTE_W(BYTE_W)) u_alu (
        .op(op_q), .a(opa_byte), .b(opb_byte), .chain_in(chain_in),
        .res(res), .flag_val(flag_val), .chain_out(chain_out), .ovf(ovf)
    );

    wseq_join #(.BYTE_W(BYTE_W)) u_join (
        .clk(clk), .rst_n(rst_n), .op_q(op_q), .wide_q(wide_q),
        .cin_q(cin_q), .pass_en(pass_en), .second(second),
        .fetch_hi(fetch_hi), .last_pass(last_pass), .res(res),
        .flag_val(flag_val), .chain_out(chain_out), .ovf(ovf),
        .chain_to_alu(chain_in), .done(done), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );
endmodule

// File: rtl/wseq_checker.sv
// Port-level protocol checker for wide_alu_seq, attached by bind.
// Assumes rst_n is low from time zero until the first clock edges.
module wseq_checker
    import wseq_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OP_W-1:0]   op,
    input logic              wide,
    input logic              busy,
    input logic              fetch_hi,
    input logic              done,
    input logic [WORD_W-1:0] result,
    input logic              flag_z,
    input logic              flag_v
);
    logic [OP_W-1:0] op_cap;
    logic            accept;

    assign accept = start && !busy;

    // Remember the code of the operation in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)      op_cap <= '0;
        else if (accept) op_cap <= op;
    end

    assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_narrow_one_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wide) |=> busy ##1 (done && result[WORD_W-1:BYTE_W] == '0));

    assert_wide_two_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wide) |=> busy ##1 busy ##1 done);

    assert_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wide && op != OP_LSR && op != OP_ROR) |=> !fetch_hi ##1 fetch_hi);

    assert_high_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wide && (op == OP_LSR || op == OP_ROR)) |=> fetch_hi ##1 !fetch_hi);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_cap != OP_CMP) |-> (flag_z == (result == '0)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_cap != OP_ADC && op_cap != OP_SBC) |-> !flag_v);
endmodule

bind wide_alu_seq wseq_checker #(.BYTE_W(BYTE_W)) u_wseq_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
    .busy(busy), .fetch_hi(fetch_hi), .done(done), .result(result),
    .flag_z(flag_z), .flag_v(flag_v)
);

// File: tb/wide_alu_seq_tb_top.sv
// Self-checking bench with a behavioural full-width reference model.
module wide_alu_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_s = '0;
    logic        wide_s = 1'b0;
    logic        cin_s = 1'b0;
    logic [7:0]  opa = '0;
    logic [7:0]  opb = '0;
    logic        busy, fetch_hi, done, flag_n, flag_z, flag_c, flag_v;
    logic [15:0] result;
    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    wide_alu_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_s), .wide(wide_s),
        .carry_in(cin_s), .opa_byte(opa), .opb_byte(opb), .busy(busy),
        .fetch_hi(fetch_hi), .done(done), .result(result), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference: compute the operation directly at 8 or 16 bits.
    task automatic model(input int opc, input bit w, input bit ci, input int a_in,
                         input int b_in, output int r, output bit n, output bit z,
                         output bit c, output bit v);
        int width, mask, top, s, fv, a, b, nb;
        width = w ? 16 : 8;
        mask  = (1 << width) - 1;
        top   = 1 << (width - 1);
        a = a_in & mask;
        b = b_in & mask;
        nb = (~b) & mask;
        c = ci; v = 1'b0; r = b; fv = -1;
        case (opc)
            0: r = a | b;
            1: r = a & b;
            2: r = a ^ b;
            3: begin s = a + b + int'(ci); r = s & mask; c = ((s >> width) & 1) != 0;
                     v = ((a & top) == (b & top)) && ((r & top) != (a & top)); end
            4: begin s = a + nb + int'(ci); r = s & mask; c = ((s >> width) & 1) != 0;
                     v = ((a & top) == (nb & top)) && ((r & top) != (a & top)); end
            5: begin s = a + nb + 1; r = a; fv = s & mask; c = ((s >> width) & 1) != 0; end
            7: r = a;
            8: r = (b + 1) & mask;
            9: r = (b - 1) & mask;
            10: begin r = (b << 1) & mask; c = (b & top) != 0; end
            11: begin r = ((b << 1) | int'(ci)) & mask; c = (b & top) != 0; end
            12: begin r = b >> 1; c = (b & 1) != 0; end
            13: begin r = (b >> 1) | (ci ? top : 0); c = (b & 1) != 0; end
            default: r = b;
        endcase
        if (opc != 5) fv = r;
        n = (fv & top) != 0;
        z = (fv == 0);
    endtask

    // Drive one operation; compare handshake every cycle and outputs at done.
    task automatic run_op(input int opc, input bit w, input bit ci,
                          input logic [15:0] a, input logic [15:0] b, input bit poke = 1'b0);
        int r; bit n, z, c, v, hf;
        string rt;
        model(opc, w, ci, int'(a), int'(b), r, n, z, c, v);
        hf = w && (opc == 12 || opc == 13);
        rt = poke ? "R10" : (opc == 5) ? "R9" : (w && (opc == 8 || opc == 9)) ? "R8"
           : w ? (hf ? "R4" : "R3") : "R12";
        @(negedge clk);
        start = 1'b1; op_s = 4'(opc); wide_s = w; cin_s = ci;
        @(negedge clk);
        start = poke;
        if (poke) begin op_s = 4'(opc ^ 1); cin_s = ~ci; wide_s = ~w; end
        chk(busy === 1'b1 && done === 1'b0, "R1 first pass busy", int'(busy), 1);
        chk(fetch_hi === hf, hf ? "R4 first half" : "R3 first half", int'(fetch_hi), int'(hf));
        opa = hf ? a[15:8] : a[7:0];
        opb = hf ? b[15:8] : b[7:0];
        if (w) begin
            @(negedge clk);
            start = 1'b0;
            chk(busy === 1'b1 && done === 1'b0, "R1 second pass busy", int'(busy), 1);
            chk(fetch_hi === !hf, hf ? "R4 second half" : "R3 second half",
                int'(fetch_hi), int'(!hf));
            opa = hf ? a[7:0] : a[15:8];
            opb = hf ? b[7:0] : b[15:8];
        end
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R1 done pulse", int'(done), 1);
        chk(int'(result) == r, {rt, " result"}, int'(result), r);
        chk(flag_n === n, "R5 N", int'(flag_n), int'(n));
        chk(flag_z === z, "R5 Z", int'(flag_z), int'(z));
        chk(flag_c === c, "R7 C", int'(flag_c), int'(c));
        chk(flag_v === v, "R6 V", int'(flag_v), int'(v));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy === 0 && done === 0 && result === 16'h0, "R11 reset outputs", int'(result), 0);
        chk({flag_n, flag_z, flag_c, flag_v} === 4'b0, "R11 reset flags",
            int'({flag_n, flag_z, flag_c, flag_v}), 0);
        rst_n = 1'b1;
        // Carry and borrow chaining, boundary cases
        run_op(3, 1, 0, 16'h00FF, 16'h0001);   // R3 -> 0x0100
        run_op(4, 1, 1, 16'h1000, 16'h0001);   // R3 -> 0x0FFF
        run_op(3, 1, 0, 16'h7FFF, 16'h0001);   // R6 overflow, N set
        run_op(4, 1, 1, 16'h8000, 16'h0001);   // R6 overflow on subtract
        run_op(8, 1, 0, 16'h0000, 16'h00FF);   // R8 -> 0x0100
        run_op(9, 1, 1, 16'h0000, 16'h0100);   // R8 -> 0x00FF
        run_op(8, 1, 1, 16'h0000, 16'hFFFF);   // R8 -> 0x0000, Z set
        run_op(10, 1, 0, 16'h0000, 16'h0080);  // R3 shift bit into high byte
        run_op(11, 1, 1, 16'h0000, 16'h8080);  // R3 rotate left
        run_op(12, 1, 0, 16'h0000, 16'h0100);  // R4 -> 0x0080
        run_op(13, 1, 1, 16'h0000, 16'h0001);  // R4 -> 0x8000, C set
        run_op(5, 1, 0, 16'h1234, 16'h1234);   // R9 equal
        run_op(5, 1, 0, 16'h1200, 16'h1300);   // R9 borrow
        run_op(6, 1, 0, 16'h0000, 16'h0100);   // R5 low byte zero, Z clear
        run_op(3, 0, 0, 16'hAA7F, 16'h5501);   // R12 narrow overflow
        run_op(12, 0, 1, 16'h0000, 16'hFF01);  // R12 narrow right shift
        run_op(3, 1, 0, 16'h0102, 16'h0304, 1'b1); // R10 poke while busy
        run_op(10, 0, 0, 16'h0000, 16'h0081, 1'b1); // R10 narrow poke
        // R11 outputs hold while idle
        held = result;
        repeat (3) @(negedge clk);
        chk(result === held && done === 1'b0, "R11 hold while idle", int'(result), int'(held));
        // R2 mixed codes, both widths
        for (int i = 0; i < 400; i++)
            run_op(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule